// File: doc/BRIEF.md
# SPI Flash Menu-Driven Cycle Engine

This block runs single-lane SPI flash cycles (mode 0) that a host sets up through a small register window. The host never sends a raw opcode. It fills a table of eight one-byte opcodes and a 2-bit kind field for each table entry, then writes the control word with an entry index. The kind of the chosen entry decides whether a 24-bit address follows the opcode and whether the data bytes go out from the 64-byte buffer or come back into it.

A control bit asks for an atomic prefix. The engine then sends the byte held in the prefix register as a frame of its own, for example a write enable. Chip select goes high for a guard gap, and the main frame follows before any other cycle can start. A sticky lock bit freezes the opcode table, the kind field and the prefix register. The SPI clock is the system clock divided by one of two half-period settings, and a control bit picks the fast one or the slow one.

Top module: `spi_seq_engine`

Register window (word addresses): 0 control, 1 status, 2 address, 3 prefix, 4 kinds, 5 opcodes 0..3, 6 opcodes 4..7, 7 lock, 16..31 data buffer. Buffer byte 4w+j sits in bits [8j+7:8j] of word 16+w. Opcode entry i sits in bits [8(i%4)+7:8(i%4)] of its table word. Control bits: go [0], atomic prefix [2], data present [3], entry index [6:4], fast clock [7], byte count minus one [13:8]. Status bits: in progress [0], done [1], error [2].

## Requirements
- R1: After reset the status reads 0, chip select is high and SCLK is low. SCLK stays low whenever chip select is high.
- R2: The address (low 24 bits), prefix (8 bits), kinds (16 bits), both opcode words and the buffer words read back what was last written to them, while unlocked.
- R3: A cycle sends the opcode of entry index[6:4]. If the entry's kind is 2 or 3, the 24-bit address follows with its most significant byte first. If the kind is 1 or 3 and data present is set, buffer bytes 0..count follow. Entry i's kind is in bits [2i+1:2i] of the kinds register: 0 read without address, 1 write without address, 2 read with address, 3 write with address.
- R4: For read kinds with data present, count+1 bytes (1 to 64) are clocked in and stored into buffer bytes 0..count. Each bit is sampled on a rising SCLK edge.
- R5: With the atomic bit set, the prefix byte goes out alone in its own chip-select frame. Chip select then stays high for at least two SCLK periods, and the main frame follows.
- R6: Writing 1 to lock bit 0 sets the lock for good; only reset clears it. While it is set, writes to the prefix, kinds and opcode registers have no effect.
- R7: In-progress rises on the clock after an accepted go write. It falls in the same clock in which done is set.
- R8: Writing 1 to status bit 1 or bit 2 clears done or error.
- R9: A go write while a cycle is in progress is ignored. The running frame, its length and the status are unaffected.
- R10: A go whose entry has a read kind without data present starts no frame. It sets error instead.
- R11: SCLK has a period of 2*HALF_SLOW system clocks, or 2*HALF_FAST when control bit 7 is set.
- R12: A write kind with data present clear sends only the opcode, plus the address for kind 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| spiCsN | output | 1 | Flash chip select, active low |
| spiSclk | output | 1 | SPI clock, idle low |
| spiMosi | output | 1 | Serial data to flash |
| spiMiso | input | 1 | Serial data from flash |

## Verification
The hardest state to reach from the ports is a second go that lands while a frame is still shifting. The bench starts a long slow write and, some dozens of clocks later, writes a go that would raise an error if it were accepted. It then checks that exactly one frame of the original length appeared and that error stayed clear. A flash model on the bench records every chip-select frame and drives a position-dependent pattern on MISO. This lets the 64-byte boundary read, the prefix gap and the clock period all be judged from the pins.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int BUF_BYTES = 64;
  localparam int CNT_W     = $clog2(BUF_BYTES);
  localparam int WORD_W    = CNT_W - 2;
  localparam int REG_AW    = WORD_W + 1;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PRE, PH_GAP, PH_OP, PH_ADDR, PH_DATA
  } phase_e;

  // host-side strobes decoded by the datapath
  typedef struct packed {
    logic             start;
    logic             clrDone;
    logic             clrErr;
    logic             atomic;
    logic             dataOn;
    logic             fast;
    logic [2:0]       idx;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       kind;
  } cmd_t;

  // control-side strobes steering the datapath
  typedef struct packed {
    phase_e           phase;
    logic [2:0]       idx;
    logic [CNT_W-1:0] byteIdx;
    logic [CNT_W-1:0] wrIdx;
    logic             load;
    logic             shift;
    logic             sample;
    logic             store;
  } strb_t;
endpackage

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int HALF_SLOW = 4,
  parameter int HALF_FAST = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  cmd_t   cmd,
  output strb_t  strb,
  output logic   csN,
  output logic   sclk,
  output logic   busy,
  output logic   done,
  output logic   err
);
  localparam int HMAX  = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
  localparam int DIV_W = $clog2(HMAX) + 1;
  localparam logic [DIV_W-1:0] RL_SLOW = DIV_W'(HALF_SLOW - 1);
  localparam logic [DIV_W-1:0] RL_FAST = DIV_W'(HALF_FAST - 1);

  phase_e           phase, phaseN;
  logic [CNT_W-1:0] byteIdx, byteN, cntQ;
  logic [2:0]       bitCnt, bitN, idxQ;
  logic [1:0]       gapCnt, gapN;
  logic [DIV_W-1:0] divCnt, divN, reload;
  logic             sclkQ, sclkN, csNQ, csNN;
  logic             fastQ, addrQ, writeQ, dataQ, pendQ;
  logic             tick, conflict, accept, doneSet, errSet;
  logic             loadS, shiftS, sampleS, storeS;

  assign reload   = fastQ ? RL_FAST : RL_SLOW;
  assign tick     = (divCnt == '0);
  assign conflict = cmd.start && (phase == PH_IDLE) && !cmd.kind[0] && !cmd.dataOn;
  assign accept   = cmd.start && (phase == PH_IDLE) && !conflict;

  always_comb begin
    phaseN = phase; byteN = byteIdx; bitN = bitCnt; gapN = gapCnt;
    sclkN = sclkQ; csNN = csNQ;
    divN = tick ? reload : divCnt - 1'b1;
    loadS = 1'b0; shiftS = 1'b0; sampleS = 1'b0; storeS = 1'b0;
    doneSet = 1'b0; errSet = 1'b0;
    case (phase)
      PH_IDLE: begin
        divN = reload;
        if (conflict) errSet = 1'b1;
        else if (accept) begin
          phaseN = cmd.atomic ? PH_PRE : PH_OP;
          byteN = '0; bitN = '0; csNN = 1'b0; loadS = 1'b1;
          divN = cmd.fast ? RL_FAST : RL_SLOW;
        end
      end
      PH_GAP: if (tick) begin
        gapN = gapCnt + 1'b1;
        if (gapCnt == 2'd3) begin
          if (pendQ) begin
            phaseN = PH_OP; byteN = '0; csNN = 1'b0; loadS = 1'b1;
          end else begin
            phaseN = PH_IDLE; doneSet = 1'b1;
          end
        end
      end
      default: if (tick) begin
        if (!sclkQ) begin
          sclkN = 1'b1; sampleS = 1'b1;
        end else begin
          sclkN = 1'b0;
          if (bitCnt != 3'd7) begin
            bitN = bitCnt + 1'b1; shiftS = 1'b1;
          end else begin
            bitN = '0;
            storeS = (phase == PH_DATA) && !writeQ;
            // defaults to closing the frame; overridden when more bytes follow
            phaseN = PH_GAP; csNN = 1'b1; gapN = '0;
            case (phase)
              PH_OP: if (addrQ) begin
                phaseN = PH_ADDR; csNN = 1'b0; byteN = '0; loadS = 1'b1;
              end else if (dataQ) begin
                phaseN = PH_DATA; csNN = 1'b0; byteN = '0; loadS = 1'b1;
              end
              PH_ADDR: if (byteIdx != CNT_W'(2)) begin
                phaseN = PH_ADDR; csNN = 1'b0; byteN = byteIdx + 1'b1; loadS = 1'b1;
              end else if (dataQ) begin
                phaseN = PH_DATA; csNN = 1'b0; byteN = '0; loadS = 1'b1;
              end
              PH_DATA: if (byteIdx != cntQ) begin
                phaseN = PH_DATA; csNN = 1'b0; byteN = byteIdx + 1'b1; loadS = 1'b1;
              end
              default: ;
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE; byteIdx <= '0; bitCnt <= '0; gapCnt <= '0;
      divCnt <= '0; sclkQ <= 1'b0; csNQ <= 1'b1;
      fastQ <= 1'b0; addrQ <= 1'b0; writeQ <= 1'b0; dataQ <= 1'b0;
      pendQ <= 1'b0; cntQ <= '0; idxQ <= '0; done <= 1'b0; err <= 1'b0;
    end else begin
      phase <= phaseN; byteIdx <= byteN; bitCnt <= bitN; gapCnt <= gapN;
      divCnt <= divN; sclkQ <= sclkN; csNQ <= csNN;
      if (accept) begin
        fastQ <= cmd.fast; addrQ <= cmd.kind[1]; writeQ <= cmd.kind[0];
        dataQ <= cmd.dataOn; pendQ <= cmd.atomic; cntQ <= cmd.cnt; idxQ <= cmd.idx;
      end else if (phase == PH_GAP && phaseN == PH_OP) begin
        pendQ <= 1'b0;
      end
      if (doneSet) done <= 1'b1;
      else if (cmd.clrDone) done <= 1'b0;
      if (errSet) err <= 1'b1;
      else if (cmd.clrErr) err <= 1'b0;
    end
  end

  assign strb = '{phase: phaseN, idx: (accept ? cmd.idx : idxQ), byteIdx: byteN,
                  wrIdx: byteIdx, load: loadS, shift: shiftS, sample: sampleS,
                  store: storeS};
  assign csN  = csNQ;
  assign sclk = sclkQ;
  assign busy = (phase != PH_IDLE);
endmodule

// File: rtl/spi_seq_dp.sv
module spi_seq_dp
  import spi_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  strb_t             strb,
  input  logic              busy,
  input  logic              done,
  input  logic              err,
  input  logic              miso,
  output logic              mosi,
  output logic              locked,
  output cmd_t              cmd
);
  localparam logic [REG_AW-1:0] A_CTRL = 'd0, A_STAT = 'd1, A_ADDR = 'd2, A_PRE = 'd3,
                                A_KIND = 'd4, A_MLO = 'd5, A_MHI = 'd6, A_LOCK = 'd7;

  logic [15:0] ctrlQ, kindQ;
  logic [23:0] addrQ;
  logic [7:0]  preQ, txSh, rxSh, txByte;
  logic [63:0] menuQ;
  logic        lockQ;
  logic [7:0]  bufQ [BUF_BYTES];
  logic        bufSel;
  logic [WORD_W-1:0] wordIdx;

  assign bufSel  = regAddr[REG_AW-1];
  assign wordIdx = regAddr[WORD_W-1:0];

  always_comb begin
    cmd.start   = regWe && (regAddr == A_CTRL) && regWdata[0];
    cmd.clrDone = regWe && (regAddr == A_STAT) && regWdata[1];
    cmd.clrErr  = regWe && (regAddr == A_STAT) && regWdata[2];
    cmd.atomic  = regWdata[2];
    cmd.dataOn  = regWdata[3];
    cmd.idx     = regWdata[6:4];
    cmd.fast    = regWdata[7];
    cmd.cnt     = regWdata[8 +: CNT_W];
    cmd.kind    = kindQ[2*regWdata[6:4] +: 2];
  end

  always_comb begin
    case (strb.phase)
      PH_PRE:  txByte = preQ;
      PH_OP:   txByte = menuQ[8*strb.idx +: 8];
      PH_ADDR: txByte = addrQ[8*(2 - strb.byteIdx[1:0]) +: 8];
      PH_DATA: txByte = bufQ[strb.byteIdx];
      default: txByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0; kindQ <= '0; addrQ <= '0; preQ <= '0; menuQ <= '0; lockQ <= 1'b0;
      txSh <= '0; rxSh <= '0;
      for (int i = 0; i < BUF_BYTES; i++) bufQ[i] <= '0;
    end else begin
      if (regWe && !bufSel) begin
        case (regAddr)
          A_CTRL: if (!busy) ctrlQ <= regWdata[15:0];
          A_ADDR: addrQ <= regWdata[23:0];
          A_PRE:  if (!lockQ) preQ <= regWdata[7:0];
          A_KIND: if (!lockQ) kindQ <= regWdata[15:0];
          A_MLO:  if (!lockQ) menuQ[31:0] <= regWdata;
          A_MHI:  if (!lockQ) menuQ[63:32] <= regWdata;
          A_LOCK: if (regWdata[0]) lockQ <= 1'b1;
          default: ;
        endcase
      end
      if (regWe && bufSel)
        for (int j = 0; j < 4; j++) bufQ[{wordIdx, 2'(j)}] <= regWdata[8*j +: 8];
      if (strb.store) bufQ[strb.wrIdx] <= rxSh;
      if (strb.load) txSh <= txByte;
      else if (strb.shift) txSh <= {txSh[6:0], 1'b0};
      if (strb.sample) rxSh <= {rxSh[6:0], miso};
    end
  end

  always_comb begin
    regRdata = '0;
    if (bufSel) begin
      for (int j = 0; j < 4; j++) regRdata[8*j +: 8] = bufQ[{wordIdx, 2'(j)}];
    end else begin
      case (regAddr)
        A_CTRL: regRdata = {16'h0, ctrlQ};
        A_STAT: regRdata = {29'h0, err, done, busy};
        A_ADDR: regRdata = {8'h0, addrQ};
        A_PRE:  regRdata = {24'h0, preQ};
        A_KIND: regRdata = {16'h0, kindQ};
        A_MLO:  regRdata = menuQ[31:0];
        A_MHI:  regRdata = menuQ[63:32];
        A_LOCK: regRdata = {31'h0, lockQ};
        default: regRdata = '0;
      endcase
    end
  end

  assign mosi   = txSh[7];
  assign locked = lockQ;
endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
  import spi_seq_pkg::*;
#(
  parameter int HALF_SLOW = 4,
  parameter int HALF_FAST = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              spiCsN,
  output logic              spiSclk,
  output logic              spiMosi,
  input  logic              spiMiso
);
  cmd_t  cmdW;
  strb_t strbW;
  logic  busyW, doneW, errW, lockW;

  spi_seq_dp dp_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .strb(strbW), .busy(busyW), .done(doneW), .err(errW),
    .miso(spiMiso), .mosi(spiMosi), .locked(lockW), .cmd(cmdW)
  );

  spi_seq_ctrl #(.HALF_SLOW(HALF_SLOW), .HALF_FAST(HALF_FAST)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmd(cmdW), .strb(strbW), .csN(spiCsN), .sclk(spiSclk),
    .busy(busyW), .done(doneW), .err(errW)
  );
endmodule

// File: rtl/spi_seq_checker.sv
module spi_seq_checker
  import spi_seq_pkg::*;
(
  input logic clk,
  input logic rstN,
  input cmd_t cmd,
  input logic busy,
  input logic done,
  input logic err,
  input logic locked,
  input logic csN,
  input logic sclk
);
  logic goGood, goBad;
  assign goGood = cmd.start && !busy && (cmd.kind[0] || cmd.dataOn);
  assign goBad  = cmd.start && !busy && !cmd.kind[0] && !cmd.dataOn;

  p_go_busy_r7: assert property (@(posedge clk) disable iff (!rstN) goGood |=> busy);
  p_done_fall_r7: assert property (@(posedge clk) disable iff (!rstN) $fell(busy) |-> done);
  p_conflict_err_r10: assert property (@(posedge clk) disable iff (!rstN)
    goBad |=> (err && !busy && csN));
  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rstN) locked |=> locked);
  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rstN) !busy |-> (csN && !sclk));
  p_sclk_low_r1: assert property (@(posedge clk) disable iff (!rstN) csN |-> !sclk);
endmodule

bind spi_seq_engine spi_seq_checker chk_i (
  .clk(clk), .rstN(rstN), .cmd(cmdW), .busy(busyW), .done(doneW), .err(errW),
  .locked(lockW), .csN(spiCsN), .sclk(spiSclk)
);

// File: tb/spi_seq_engine_tb_top.sv
module spi_seq_engine_tb_top;
  localparam int HS = 4, HF = 2, TCK = 4;

  logic clk = 1'b0, rstN = 1'b0, regWe = 1'b0, miso = 1'b0;
  logic [4:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic csN, sclk, mosi;

  spi_seq_engine #(.HALF_SLOW(HS), .HALF_FAST(HF)) dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .spiCsN(csN), .spiSclk(sclk), .spiMosi(mosi), .spiMiso(miso)
  );

  always #(TCK/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  // flash model: records frames, drives a position pattern on MISO
  logic [7:0] frm [16][80];
  int flen [16];
  int fc = 0, blen = 0, bitc = 0, lastGap = 0, lastPer = 0;
  time tRise = 0, tPrevSclk = 0;
  logic [7:0] sh = '0;

  function automatic logic [7:0] resp(int p);
    return 8'(8'h3C + p * 8'h11);
  endfunction

  always @(negedge csN) begin
    blen = 0; bitc = 0;
    if (fc > 0) lastGap = int'(($time - tRise) / TCK);
    miso = resp(0)[7];
  end
  always @(posedge csN) begin
    if (fc < 16) flen[fc] = blen;
    fc++; tRise = $time;
  end
  always @(posedge sclk) if (!csN) begin
    if (bitc > 0) lastPer = int'(($time - tPrevSclk) / TCK);
    tPrevSclk = $time;
    sh = {sh[6:0], mosi};
    bitc++;
    if (bitc == 8) begin
      if (fc < 16 && blen < 80) frm[fc][blen] = sh;
      blen++; bitc = 0;
    end
  end
  always @(negedge sclk) if (!csN) miso = resp(blen)[7 - bitc];

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdata;
  endtask

  function automatic logic [31:0] mkCtrl(int idx, int cnt, bit dataOn, bit atomic, bit fast);
    return 32'(1 | (atomic << 2) | (dataOn << 3) | (idx << 4) | (fast << 7) | (cnt << 8));
  endfunction

  task automatic waitDone(output logic [31:0] s);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk); rd(5'd1, s);
      if (s[1] || s[2]) break;
    end
  endtask

  task automatic tReset();
    logic [31:0] s;
    rd(5'd1, s);
    chk(s == 0, "R1 status", s, 0);
    chk(csN === 1'b1 && sclk === 1'b0, "R1 pins", {csN, sclk}, 2'b10);
  endtask

  task automatic tRegs();
    logic [31:0] v;
    wr(5'd5, 32'hD8020B9F); wr(5'd6, 32'h44332211);
    wr(5'd4, 32'h000000F8); wr(5'd3, 32'h00000006); wr(5'd2, 32'hFF123456);
    wr(5'd16, 32'h44332211); wr(5'd17, 32'h88776655);
    rd(5'd5, v); chk(v == 32'hD8020B9F, "R2 opcodes", v, 32'hD8020B9F);
    rd(5'd4, v); chk(v == 32'hF8, "R2 kinds", v, 32'hF8);
    rd(5'd2, v); chk(v == 32'h123456, "R2 address", v, 32'h123456);
    rd(5'd17, v); chk(v == 32'h88776655, "R2 buffer", v, 32'h88776655);
  endtask

  task automatic tWriteAddr();
    logic [31:0] s;
    logic [7:0] exp [8] = '{8'h02, 8'h12, 8'h34, 8'h56, 8'h11, 8'h22, 8'h33, 8'h44};
    int f0 = fc;
    wr(5'd0, mkCtrl(2, 3, 1, 0, 0));
    rd(5'd1, s); chk(s[0] == 1'b1, "R7 in progress after go", s, 1);
    waitDone(s);
    chk(s[1:0] == 2'b10, "R7 done with in-progress low", s, 2);
    chk(fc == f0 + 1 && flen[f0] == 8, "R3 frame length", flen[f0], 8);
    for (int i = 0; i < 8; i++)
      chk(frm[f0][i] == exp[i], "R3 frame byte", frm[f0][i], exp[i]);
    chk(lastPer == 2 * HS, "R11 slow period", lastPer, 2 * HS);
    wr(5'd1, 32'h2); rd(5'd1, s); chk(s == 0, "R8 done cleared", s, 0);
  endtask

  task automatic tReadFast();
    logic [31:0] s, v, e;
    int f0 = fc;
    wr(5'd2, 32'h00ABCD);
    wr(5'd0, mkCtrl(1, 5, 1, 0, 1));
    waitDone(s);
    chk(flen[f0] == 10, "R4 read frame length", flen[f0], 10);
    chk(frm[f0][0] == 8'h0B && frm[f0][1] == 8'h00 && frm[f0][3] == 8'hCD,
        "R3 read address", {frm[f0][0], frm[f0][1], frm[f0][3]}, 24'h0B00CD);
    rd(5'd16, v); e = {resp(7), resp(6), resp(5), resp(4)};
    chk(v == e, "R4 read word 0", v, e);
    rd(5'd17, v); e = {16'h8877, resp(9), resp(8)};
    chk(v == e, "R4 read word 1 partial", v, e);
    chk(lastPer == 2 * HF, "R11 fast period", lastPer, 2 * HF);
    wr(5'd1, 32'h2);
  endtask

  task automatic tRead64();
    logic [31:0] s, v, e;
    int f0 = fc;
    wr(5'd0, mkCtrl(0, 63, 1, 0, 0));
    waitDone(s);
    chk(flen[f0] == 65 && frm[f0][0] == 8'h9F, "R4 64-byte frame", flen[f0], 65);
    rd(5'd31, v); e = {resp(64), resp(63), resp(62), resp(61)};
    chk(v == e, "R4 last buffer word", v, e);
    rd(5'd16, v); e = {resp(4), resp(3), resp(2), resp(1)};
    chk(v == e, "R4 first buffer word", v, e);
    wr(5'd1, 32'h2);
  endtask

  task automatic tAtomic();
    logic [31:0] s;
    int f0 = fc;
    wr(5'd2, 32'h00654321);
    wr(5'd0, mkCtrl(3, 0, 0, 1, 0));
    waitDone(s);
    chk(fc == f0 + 2, "R5 two frames", fc - f0, 2);
    chk(flen[f0] == 1 && frm[f0][0] == 8'h06, "R5 prefix frame", {flen[f0][7:0], frm[f0][0]}, 16'h0106);
    chk(lastGap >= 4 * HS, "R5 chip select gap", lastGap, 4 * HS);
    chk(flen[f0+1] == 4 && frm[f0+1][0] == 8'hD8 && frm[f0+1][1] == 8'h65 && frm[f0+1][3] == 8'h21,
        "R12 opcode and address only", flen[f0+1], 4);
    wr(5'd1, 32'h2);
  endtask

  task automatic tBusyGo();
    logic [31:0] s;
    int f0 = fc;
    wr(5'd0, mkCtrl(2, 7, 1, 0, 0));
    repeat (60) @(negedge clk);
    wr(5'd0, mkCtrl(0, 2, 0, 0, 1));
    waitDone(s);
    chk(fc == f0 + 1 && flen[f0] == 12, "R9 single unchanged frame", flen[f0], 12);
    chk(s[2:0] == 3'b010, "R9 no error from ignored go", s, 3'b010);
    wr(5'd1, 32'h2);
  endtask

  task automatic tConflict();
    logic [31:0] s;
    int f0 = fc;
    wr(5'd0, mkCtrl(0, 0, 0, 0, 0));
    rd(5'd1, s); chk(s == 32'h4, "R10 error, not started", s, 4);
    repeat (40) @(negedge clk);
    chk(fc == f0 && csN === 1'b1, "R10 no frame", fc - f0, 0);
    wr(5'd1, 32'h4); rd(5'd1, s); chk(s == 0, "R8 error cleared", s, 0);
  endtask

  task automatic tLock();
    logic [31:0] v;
    wr(5'd7, 32'h1);
    wr(5'd5, 32'h01010101); wr(5'd4, 32'hFFFF); wr(5'd3, 32'h77); wr(5'd2, 32'h00AA55);
    rd(5'd5, v); chk(v == 32'hD8020B9F, "R6 opcodes frozen", v, 32'hD8020B9F);
    rd(5'd4, v); chk(v == 32'hF8, "R6 kinds frozen", v, 32'hF8);
    rd(5'd3, v); chk(v == 32'h06, "R6 prefix frozen", v, 32'h06);
    rd(5'd2, v); chk(v == 32'h00AA55, "R2 address still writable", v, 32'h00AA55);
    wr(5'd7, 32'h0); rd(5'd7, v); chk(v == 1, "R6 lock sticky", v, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset(); tRegs(); tWriteAddr(); tReadFast(); tRead64();
    tAtomic(); tBusyGo(); tConflict(); tLock();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule